// File: doc/BRIEF.md
# Restartable Two-Event Join

This block joins two independent event strobes. It watches for the first event and the second event. The two may come in any order, in separate cycles or in the same cycle. In the cycle that completes the pair, it raises a one-cycle completion pulse. After that pulse the block goes quiet and ignores further events. It stays quiet until a restart strobe reopens the wait. A restart may come at any time, including partway through a wait. Whatever was collected so far is then discarded.

The completion pulse is combinational from the current event inputs and the stored state. A consumer therefore sees it in the same cycle as the completing event. The stored state uses one pending flag per awaited event plus one halted flag. The number of joined events is a parameter; its default is two.

Top module: `evt_join`

## Requirements
- R1: After the asynchronous reset is released, the block waits for both events, and done_o stays 0 while no event arrives.
- R2: If the first event (ev_i[0]) arrives before the second event (ev_i[1]), done_o is 1 only in the cycle where ev_i[1] is seen, and is 0 in the cycle of ev_i[0].
- R3: If ev_i[1] arrives before ev_i[0], done_o is 1 only in the cycle where ev_i[0] is seen.
- R4: If both bits of ev_i are 1 in the same cycle while the block is waiting and restart_i is 0, done_o is 1 in that cycle.
- R5: done_o is 1 for at most one cycle per restart. Once it has pulsed, further events give done_o = 0 until restart_i is seen.
- R6: restart_i in any state discards the events collected so far. A new pair must complete before done_o rises again.
- R7: restart_i takes priority over events in the same cycle. done_o is 0 in that cycle, and those events are not counted. Counting starts in the next cycle.
- R8: Repeats of one event before the other arrives do not produce a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | NUM_EVT | Event strobes; bit 0 is the first event, bit 1 the second |
| restart_i | input | 1 | Restart strobe; reopens the wait |
| done_o | output | 1 | One-cycle pulse when the last outstanding event arrives |

## Verification
The hardest case to reach from the ports is a restart in the same cycle as events. The bench must show that those events were really dropped, and were not just held back. The stimulus first asserts restart together with one or both events. It then supplies only the other event and checks that no pulse appears. Finally it supplies the dropped event and confirms that the pulse comes only then. This sequence is run both from a waiting state and from the halted state.

// File: rtl/evt_join_pkg.sv
package evt_join_pkg;
  typedef enum logic {
    RUN_ST  = 1'b0,
    HALT_ST = 1'b1
  } halt_e;
endpackage

// File: rtl/evt_join_wait.sv
module evt_join_wait (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  input  logic ev_i,
  output logic ready_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (restart_i)          pend_d = 1'b1;
    else if (run_i && ev_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b1;
    else         pend_q <= pend_d;
  end

  // satisfied if already seen or arriving now
  assign ready_o = !pend_q || ev_i;
endmodule

// File: rtl/evt_join_halt.sv
module evt_join_halt
  import evt_join_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic fire_i,
  output logic run_o
);
  halt_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (restart_i)   st_d = RUN_ST;
    else if (fire_i) st_d = HALT_ST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= RUN_ST;
    else         st_q <= st_d;
  end

  assign run_o = (st_q == RUN_ST);
endmodule

// File: rtl/evt_join.sv
module evt_join #(
  parameter int unsigned NUM_EVT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] ev_i,
  input  logic               restart_i,
  output logic               done_o
);
  logic [NUM_EVT-1:0] ready;
  logic               run;
  logic               fire;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_wait
    evt_join_wait u_wait (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .restart_i(restart_i),
      .run_i    (run),
      .ev_i     (ev_i[i]),
      .ready_o  (ready[i])
    );
  end

  evt_join_halt u_halt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart_i),
    .fire_i   (fire),
    .run_o    (run)
  );

  assign fire   = run && !restart_i && (&ready);
  assign done_o = fire;
endmodule

// File: rtl/evt_join_chk.sv
module evt_join_chk #(
  parameter int unsigned NUM_EVT = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] ev_i,
  input logic               restart_i,
  input logic               done_o
);
  logic fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fired_q <= 1'b0;
    else if (restart_i) fired_q <= 1'b0;
    else if (done_o)    fired_q <= 1'b1;
  end

  // R1
  pulse_needs_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (|ev_i));

  // R4
  joint_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&ev_i) && !restart_i && !fired_q) |-> done_o);

  // R5
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fired_q |-> !done_o);

  // R6
  fresh_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i ##1 ($countones(ev_i) != NUM_EVT) |-> !done_o);

  // R7
  restart_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |-> !done_o);
endmodule

bind evt_join evt_join_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ev_i     (ev_i),
  .restart_i(restart_i),
  .done_o   (done_o)
);

// File: tb/evt_join_tb.sv
module evt_join_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ev = 2'b00;
  logic       restart = 1'b0;
  logic       done;
  int         n_run = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  evt_join #(.NUM_EVT(2)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .ev_i     (ev),
    .restart_i(restart),
    .done_o   (done)
  );

  // drive after falling edge, sample 1 ns later, then let the rising edge pass
  task automatic step(input logic a, input logic b, input logic r,
                      input logic exp, input string tag);
    @(negedge clk);
    ev = {b, a};
    restart = r;
    #1;
    n_run++;
    if (done !== exp) begin
      n_fail++;
      $display("FAIL %s: done_o=%0b expected %0b", tag, done, exp);
    end
    @(posedge clk);
  endtask

  task automatic clr();
    step(1'b0, 1'b0, 1'b1, 1'b0, "R7");
  endtask

  task automatic t_reset();
    step(0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, "R1");
  endtask

  task automatic t_a_then_b();
    step(1, 0, 0, 0, "R2");
    step(0, 0, 0, 0, "R2");
    step(0, 1, 0, 1, "R2");
    step(0, 0, 0, 0, "R5");
    clr();
  endtask

  task automatic t_b_then_a();
    step(0, 1, 0, 0, "R3");
    step(0, 1, 0, 0, "R3");
    step(1, 0, 0, 1, "R3");
    step(1, 0, 0, 0, "R5");
    clr();
  endtask

  task automatic t_both();
    step(1, 1, 0, 1, "R4");
    step(1, 1, 0, 0, "R5");
    step(1, 0, 0, 0, "R5");
    step(0, 1, 0, 0, "R5");
    clr();
  endtask

  task automatic t_repeat();
    step(1, 0, 0, 0, "R8");
    step(1, 0, 0, 0, "R8");
    step(1, 0, 0, 0, "R8");
    step(0, 1, 0, 1, "R8");
    clr();
  endtask

  task automatic t_restart_mid();
    step(1, 0, 0, 0, "R6");
    step(0, 0, 1, 0, "R6");
    step(0, 1, 0, 0, "R6");
    step(1, 0, 0, 1, "R6");
    clr();
  endtask

  task automatic t_restart_events();
    step(1, 1, 1, 0, "R7");
    step(0, 1, 0, 0, "R7");
    step(1, 0, 0, 1, "R7");
    step(1, 0, 1, 0, "R7");
    step(0, 1, 0, 0, "R7");
    step(1, 0, 0, 1, "R7");
    clr();
    step(0, 1, 1, 0, "R7");
    step(0, 0, 0, 0, "R7");
    step(1, 0, 0, 0, "R7");
    step(0, 1, 0, 1, "R7");
    clr();
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_a_then_b();
    t_b_then_a();
    t_both();
    t_repeat();
    t_restart_mid();
    t_restart_events();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule